// File: doc/BRIEF.md
# Bridge Delayed-Transaction Queue

This block sits behind the target interface on the initiator side of a two-port bus bridge. It sorts each incoming request by command. A memory write, or a memory write that also invalidates, goes into a posted-write buffer and is acknowledged at once. It then drains toward the far bus over its own valid/ready stream. Every other command is answered with a retry and recorded in a small delayed-request table. Table entries are offered, oldest first, to the master on the target side.

The target side returns a completion for each issued entry, carrying a tag, a status bit and read data. The block keeps the completion until the initiator repeats the same request, and then finishes that request locally with the stored data or status. A read completion is held back while posted writes that arrived before the read are still in the buffer. A completion that nobody collects within a fixed window is thrown away, and a one-cycle event marks the loss.

Back-pressure: `pw_valid` and `dr_valid` stay high, with their payload unchanged, until the consumer raises the matching ready. Completions on the `cp_*` pins are always taken. Initiator requests are not flow-controlled. Each cycle with `init_valid` high is answered exactly one cycle later on the `rsp_*` pins.

Top module: `dtq_bridge_queue`

## Requirements
- R1: Commands 4'b0111 (memory write) and 4'b1111 (write with invalidate) are posted. When the buffer has room they get response code 0 (accept), and they appear on the `pw_*` stream in arrival order with `pw_inval` set only for 4'b1111. Payload is held while `pw_ready` is low.
- R2: A posted command that arrives while the posted buffer holds PW_DEPTH (default 4) writes gets code 1 (retry) and is not buffered.
- R3: I/O write (4'b0011) and configuration write (4'b1011) get code 1 (retry) and are recorded as delayed requests, including their write data.
- R4: Every other non-posted command, including every read, gets code 1 (retry) and is recorded as a delayed request.
- R5: A repeated request whose entry has no completion yet gets code 1 (retry). Once the completion has arrived, a repeat gets code 2 (done) with the stored read data on `rsp_rdata`, and the entry is freed.
- R6: A repeat matches an entry only if command, address and byte enables are all equal. Any difference makes a new entry, and at most one entry ever matches.
- R7: With NQ (default 4) entries in use, a new delayed request gets code 1 (retry) and is not recorded.
- R8: Delayed requests appear on the `dr_*` stream in arrival order, each carrying its entry tag. Each stays stable until accepted.
- R9: A read completion is not returned while posted writes accepted before that read are still buffered. Posted writes accepted after the read do not hold it back.
- R10: A completion not collected within DISCARD (default 1024) cycles of its arrival frees its entry, and `discard_pulse` is high for one cycle.
- R11: A completion with `cp_ok` low is reported to the matching repeat as code 3 (abort) and frees the entry.
- R12: After reset `rsp_valid`, `pw_valid`, `dr_valid` and `discard_pulse` are low, and every `init_valid` cycle is answered by `rsp_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Initiator request present this cycle |
| init_cmd | input | 4 | Bus command code |
| init_addr | input | AW | Request address |
| init_be | input | 4 | Byte enables |
| init_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 0 accept, 1 retry, 2 done, 3 abort |
| rsp_rdata | output | DW | Read data with a done response |
| pw_valid | output | 1 | Posted write available |
| pw_ready | input | 1 | Posted write consumer ready |
| pw_inval | output | 1 | Posted write was the invalidate variant |
| pw_addr | output | AW | Posted write address |
| pw_be | output | 4 | Posted write byte enables |
| pw_data | output | DW | Posted write data |
| dr_valid | output | 1 | Delayed request available |
| dr_ready | input | 1 | Target-side master takes the request |
| dr_tag | output | log2(NQ) | Entry tag of the request |
| dr_cmd | output | 4 | Request command |
| dr_addr | output | AW | Request address |
| dr_be | output | 4 | Request byte enables |
| dr_wdata | output | DW | Request write data |
| cp_valid | input | 1 | Completion present |
| cp_tag | input | log2(NQ) | Tag of the completed entry |
| cp_ok | input | 1 | Completion status, 1 = normal |
| cp_rdata | input | DW | Completion read data |
| discard_pulse | output | 1 | An uncollected completion was dropped |

## Verification
Posted bursts are driven against a stalled consumer to show the acceptance limit and the in-order drain. Delayed writes, configuration reads and I/O reads are then repeated before and after completion, which separates the retry answer from the done answer. Near-miss repeats that change only the byte enables show whether the match is exact rather than address-only. Interleavings of posted writes around a read separate older writes, which must block the read, from younger writes, which must not. Two idle windows, one just inside and one just past the discard limit, pin down the length of the discard timer. A seeded random mix of posted writes, drains and read round trips then checks data order and payloads against values computed in the bench.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'd0,
    RSP_RETRY  = 2'd1,
    RSP_DONE   = 2'd2,
    RSP_ABORT  = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_QUEUED = 2'd1,
    ST_ISSUED = 2'd2,
    ST_READY  = 2'd3
  } ent_st_e;

  function automatic logic cmd_posted(input logic [3:0] c);
    return (c == 4'b0111) || (c == 4'b1111);
  endfunction

  function automatic logic cmd_dly_write(input logic [3:0] c);
    return (c == 4'b0011) || (c == 4'b1011);
  endfunction

endpackage

// File: rtl/dtq_fifo.sv
module dtq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R1 / R8: a stalled head keeps its contents
  assert_head_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(dout)));

endmodule

// File: rtl/dtq_entry.sv
module dtq_entry
  import dtq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int OW      = 3,
  parameter int DISCARD = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [3:0]    a_cmd,
  input  logic [AW-1:0] a_addr,
  input  logic [3:0]    a_be,
  input  logic [DW-1:0] a_wdata,
  input  logic [OW-1:0] a_older,
  input  logic          pw_pop,
  input  logic          issue,
  input  logic          cpl,
  input  logic          cpl_ok,
  input  logic [DW-1:0] cpl_rdata,
  input  logic          release_i,
  output ent_st_e       st,
  output logic [3:0]    cmd,
  output logic [AW-1:0] addr,
  output logic [3:0]    be,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ok,
  output logic          older_zero,
  output logic          expire
);
  localparam int CNW = (DISCARD > 1) ? $clog2(DISCARD) : 1;

  logic [CNW-1:0] age;
  logic [OW-1:0]  older;

  assign older_zero = (older == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FREE;
      age    <= '0;
      older  <= '0;
      expire <= 1'b0;
      cmd    <= '0;
      addr   <= '0;
      be     <= '0;
      wdata  <= '0;
      rdata  <= '0;
      ok     <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (pw_pop && older != '0) older <= older - 1'b1;
      unique case (st)
        ST_FREE: if (alloc) begin
          st    <= ST_QUEUED;
          cmd   <= a_cmd;
          addr  <= a_addr;
          be    <= a_be;
          wdata <= a_wdata;
          older <= a_older;
        end
        ST_QUEUED: if (issue) st <= ST_ISSUED;
        ST_ISSUED: if (cpl) begin
          st    <= ST_READY;
          rdata <= cpl_rdata;
          ok    <= cpl_ok;
          age   <= '0;
        end
        ST_READY: begin
          if (release_i) st <= ST_FREE;
          else if (age == CNW'(DISCARD - 1)) begin
            st     <= ST_FREE;
            expire <= 1'b1;
          end else age <= age + 1'b1;
        end
        default: st <= ST_FREE;
      endcase
    end
  end

  // R10: a drop only ever follows a held completion
  assert_expire_from_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (st == ST_FREE && $past(st == ST_READY)));

endmodule

// File: rtl/dtq_bridge_queue.sv
module dtq_bridge_queue
  import dtq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NQ       = 4,
  parameter int PW_DEPTH = 4,
  parameter int DISCARD  = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_valid,
  input  logic [3:0]            init_cmd,
  input  logic [AW-1:0]         init_addr,
  input  logic [3:0]            init_be,
  input  logic [DW-1:0]         init_wdata,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_code,
  output logic [DW-1:0]         rsp_rdata,
  output logic                  pw_valid,
  input  logic                  pw_ready,
  output logic                  pw_inval,
  output logic [AW-1:0]         pw_addr,
  output logic [3:0]            pw_be,
  output logic [DW-1:0]         pw_data,
  output logic                  dr_valid,
  input  logic                  dr_ready,
  output logic [$clog2(NQ)-1:0] dr_tag,
  output logic [3:0]            dr_cmd,
  output logic [AW-1:0]         dr_addr,
  output logic [3:0]            dr_be,
  output logic [DW-1:0]         dr_wdata,
  input  logic                  cp_valid,
  input  logic [$clog2(NQ)-1:0] cp_tag,
  input  logic                  cp_ok,
  input  logic [DW-1:0]         cp_rdata,
  output logic                  discard_pulse
);
  localparam int TW  = $clog2(NQ);
  localparam int PCW = $clog2(PW_DEPTH + 1);
  localparam int PWW = 1 + AW + 4 + DW;

  // ---------------- posted path ----------------
  logic           is_posted, pw_push, pw_pop, pw_empty, pw_full;
  logic [PCW-1:0] pw_count;
  logic [PWW-1:0] pw_dout;

  assign is_posted = cmd_posted(init_cmd);
  assign pw_push   = init_valid && is_posted && !pw_full;
  assign pw_valid  = !pw_empty;
  assign pw_pop    = pw_valid && pw_ready;
  assign {pw_inval, pw_addr, pw_be, pw_data} = pw_dout;

  dtq_fifo #(.W(PWW), .DEPTH(PW_DEPTH)) u_pw_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(pw_push), .din({init_cmd[3], init_addr, init_be, init_wdata}),
    .pop(pw_pop), .dout(pw_dout),
    .empty(pw_empty), .full(pw_full), .count(pw_count)
  );

  // ---------------- delayed table ----------------
  ent_st_e       e_st    [NQ];
  logic [3:0]    e_cmd   [NQ];
  logic [AW-1:0] e_addr  [NQ];
  logic [3:0]    e_be    [NQ];
  logic [DW-1:0] e_wdata [NQ];
  logic [DW-1:0] e_rdata [NQ];
  logic [NQ-1:0] e_ok, e_oz, e_expire, hit_vec;

  logic          any_hit, have_free, alloc, hit_ready, dr_pop, ord_empty, ord_full;
  logic [TW-1:0] hit_idx, free_idx, ord_head;
  logic [PCW-1:0] alloc_older;

  always_comb begin
    for (int i = 0; i < NQ; i++)
      hit_vec[i] = init_valid && !is_posted && e_st[i] != ST_FREE &&
                   e_cmd[i] == init_cmd && e_addr[i] == init_addr && e_be[i] == init_be;
  end

  always_comb begin
    any_hit   = 1'b0;
    hit_idx   = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        hit_idx = TW'(i);
      end
      if (e_st[i] == ST_FREE) begin
        have_free = 1'b1;
        free_idx  = TW'(i);
      end
    end
  end

  // reads wait for older posted writes; delayed writes do not
  assign hit_ready   = any_hit && e_st[hit_idx] == ST_READY &&
                       (cmd_dly_write(init_cmd) || e_oz[hit_idx]);
  assign alloc       = init_valid && !is_posted && !any_hit && have_free;
  assign alloc_older = pw_count - PCW'(pw_pop);
  assign dr_valid    = !ord_empty;
  assign dr_pop      = dr_valid && dr_ready;

  dtq_fifo #(.W(TW), .DEPTH(NQ)) u_order (
    .clk(clk), .rst_n(rst_n),
    .push(alloc), .din(free_idx),
    .pop(dr_pop), .dout(ord_head),
    .empty(ord_empty), .full(ord_full), .count()
  );

  for (genvar g = 0; g < NQ; g++) begin : g_ent
    dtq_entry #(.AW(AW), .DW(DW), .OW(PCW), .DISCARD(DISCARD)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc && free_idx == TW'(g)),
      .a_cmd(init_cmd), .a_addr(init_addr), .a_be(init_be), .a_wdata(init_wdata),
      .a_older(alloc_older), .pw_pop(pw_pop),
      .issue(dr_pop && ord_head == TW'(g)),
      .cpl(cp_valid && cp_tag == TW'(g)), .cpl_ok(cp_ok), .cpl_rdata(cp_rdata),
      .release_i(hit_ready && hit_idx == TW'(g)),
      .st(e_st[g]), .cmd(e_cmd[g]), .addr(e_addr[g]), .be(e_be[g]),
      .wdata(e_wdata[g]), .rdata(e_rdata[g]), .ok(e_ok[g]),
      .older_zero(e_oz[g]), .expire(e_expire[g])
    );
  end

  assign dr_tag   = ord_head;
  assign dr_cmd   = e_cmd[ord_head];
  assign dr_addr  = e_addr[ord_head];
  assign dr_be    = e_be[ord_head];
  assign dr_wdata = e_wdata[ord_head];

  // ---------------- initiator response ----------------
  rsp_e          rsp_n;
  logic [DW-1:0] rdata_n;

  always_comb begin
    rsp_n   = RSP_RETRY;
    rdata_n = '0;
    if (is_posted) rsp_n = pw_full ? RSP_RETRY : RSP_ACCEPT;
    else if (hit_ready) begin
      rsp_n   = e_ok[hit_idx] ? RSP_DONE : RSP_ABORT;
      rdata_n = e_rdata[hit_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= RSP_ACCEPT;
      rsp_rdata     <= '0;
      discard_pulse <= 1'b0;
    end else begin
      rsp_valid     <= init_valid;
      rsp_code      <= rsp_n;
      rsp_rdata     <= rdata_n;
      discard_pulse <= |e_expire;
    end
  end

  // R6: a request never matches two entries
  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8: the delayed stream holds its payload under back-pressure
  assert_dr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_tag) && $stable(dr_addr) && $stable(dr_cmd)));
  // R12: every response follows a request by one cycle
  assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(init_valid));
  // R7: the order queue never overflows
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !ord_full);

endmodule

// File: tb/sim_dtq_bridge_queue.sv
module sim_dtq_bridge_queue;
  localparam int AW = 32, DW = 32, NQ = 4, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_valid = 1'b0;
  logic [3:0] init_cmd = '0, init_be = '0;
  logic [AW-1:0] init_addr = '0;
  logic [DW-1:0] init_wdata = '0;
  logic rsp_valid; logic [1:0] rsp_code; logic [DW-1:0] rsp_rdata;
  logic pw_valid, pw_ready = 1'b0, pw_inval;
  logic [AW-1:0] pw_addr; logic [3:0] pw_be; logic [DW-1:0] pw_data;
  logic dr_valid, dr_ready = 1'b0;
  logic [TW-1:0] dr_tag; logic [3:0] dr_cmd, dr_be;
  logic [AW-1:0] dr_addr; logic [DW-1:0] dr_wdata;
  logic cp_valid = 1'b0, cp_ok = 1'b0;
  logic [TW-1:0] cp_tag = '0;
  logic [DW-1:0] cp_rdata = '0;
  logic discard_pulse;

  always #2 clk = ~clk;

  dtq_bridge_queue u0 (.*);

  int checks = 0, errors = 0, disc_cnt = 0;
  logic [1:0] g_code; logic [DW-1:0] g_rdata;
  logic [TW-1:0] g_tag; logic [3:0] g_cmd; logic [AW-1:0] g_addr; logic [DW-1:0] g_wdata;
  logic [AW-1:0] m_addr [$];
  logic [DW-1:0] m_data [$];

  always @(negedge clk) if (rst_n && discard_pulse) disc_cnt++;

  function automatic logic [DW-1:0] rd_of(input logic [AW-1:0] a);
    return a ^ 32'hC3A5_0F00;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [AW-1:0] a, input logic [3:0] b,
                      input logic [DW-1:0] d);
    @(negedge clk);
    init_valid = 1'b1; init_cmd = c; init_addr = a; init_be = b; init_wdata = d;
    @(negedge clk);
    init_valid = 1'b0;
    g_code = rsp_code; g_rdata = rsp_rdata;
    chk(rsp_valid == 1'b1, "R12 rsp_valid", rsp_valid, 1);
  endtask

  task automatic take_dr();
    @(negedge clk);
    while (!dr_valid) @(negedge clk);
    g_tag = dr_tag; g_cmd = dr_cmd; g_addr = dr_addr; g_wdata = dr_wdata;
    dr_ready = 1'b1;
    @(negedge clk);
    dr_ready = 1'b0;
  endtask

  task automatic complete(input logic [TW-1:0] t, input logic ok, input logic [DW-1:0] d);
    @(negedge clk);
    cp_valid = 1'b1; cp_tag = t; cp_ok = ok; cp_rdata = d;
    @(negedge clk);
    cp_valid = 1'b0;
  endtask

  task automatic pop_pw(input string req);
    @(negedge clk);
    chk(pw_valid == 1'b1, req, pw_valid, 1);
    if (m_addr.size() > 0) begin
      chk(pw_addr == m_addr[0] && pw_data == m_data[0], req, pw_addr, m_addr[0]);
      void'(m_addr.pop_front()); void'(m_data.pop_front());
    end
    pw_ready = 1'b1;
    @(negedge clk);
    pw_ready = 1'b0;
  endtask

  // full delayed-read round trip: retry, issue, complete, collect
  task automatic read_trip(input logic [3:0] c, input logic [AW-1:0] a, input string req);
    send(c, a, 4'hF, '0);
    chk(g_code == 2'd1, req, g_code, 1);
    take_dr();
    chk(g_addr == a && g_cmd == c, req, g_addr, a);
    complete(g_tag, 1'b1, rd_of(a));
    send(c, a, 4'hF, '0);
    chk(g_code == 2'd2 && g_rdata == rd_of(a), req, g_rdata, rd_of(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TW-1:0] t0;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !pw_valid && !dr_valid && !discard_pulse, "R12 idle after reset",
        {rsp_valid, pw_valid, dr_valid, discard_pulse}, 0);

    // R1 / R2 posted writes
    send(4'b0111, 32'h1000, 4'hF, 32'hD000); chk(g_code == 2'd0, "R1 mem write accepted", g_code, 0);
    m_addr.push_back(32'h1000); m_data.push_back(32'hD000);
    send(4'b1111, 32'h1004, 4'hF, 32'hD001); chk(g_code == 2'd0, "R1 invalidate write accepted", g_code, 0);
    m_addr.push_back(32'h1004); m_data.push_back(32'hD001);
    chk(pw_valid && pw_addr == 32'h1000 && !pw_inval, "R1 head of posted stream", pw_addr, 32'h1000);
    for (int i = 2; i < 4; i++) begin
      send(4'b0111, 32'h1000 + 4 * i, 4'h3, 32'hD000 + i);
      m_addr.push_back(32'h1000 + 4 * i); m_data.push_back(32'hD000 + i);
      chk(g_code == 2'd0, "R1 fill accepted", g_code, 0);
    end
    send(4'b0111, 32'h2000, 4'hF, 32'hEEEE); chk(g_code == 2'd1, "R2 full buffer retries", g_code, 1);
    chk(dr_valid == 1'b0, "R2 posted retry not queued", dr_valid, 0);
    pop_pw("R1 drain order 0");
    @(negedge clk); chk(pw_inval == 1'b1, "R1 invalidate flag", pw_inval, 1);
    pop_pw("R1 drain order 1"); pop_pw("R1 drain order 2"); pop_pw("R2 drain order 3");
    @(negedge clk); chk(pw_valid == 1'b0, "R2 rejected write absent", pw_valid, 0);

    // R3 / R5 delayed write
    send(4'b0011, 32'h100, 4'h1, 32'hAB); chk(g_code == 2'd1, "R3 io write retried", g_code, 1);
    take_dr();
    chk(g_cmd == 4'b0011 && g_addr == 32'h100 && g_wdata == 32'hAB, "R3 delayed write payload", g_wdata, 32'hAB);
    send(4'b0011, 32'h100, 4'h1, 32'hAB); chk(g_code == 2'd1, "R5 repeat before completion", g_code, 1);
    complete(g_tag, 1'b1, '0);
    send(4'b0011, 32'h100, 4'h1, 32'hAB); chk(g_code == 2'd2, "R5 repeat after completion", g_code, 2);
    send(4'b1011, 32'h104, 4'hF, 32'h55); chk(g_code == 2'd1, "R3 cfg write retried", g_code, 1);
    take_dr(); chk(g_cmd == 4'b1011, "R3 cfg write queued", g_cmd, 4'b1011);
    complete(g_tag, 1'b1, '0);
    send(4'b1011, 32'h104, 4'hF, 32'h55); chk(g_code == 2'd2, "R3 cfg write done", g_code, 2);

    // R6 exact match
    send(4'b1010, 32'h200, 4'hF, '0); chk(g_code == 2'd1, "R4 cfg read retried", g_code, 1);
    take_dr(); t0 = g_tag;
    complete(t0, 1'b1, 32'h1234);
    send(4'b1010, 32'h200, 4'h3, '0); chk(g_code == 2'd1, "R6 byte enable differs", g_code, 1);
    @(negedge clk); chk(dr_valid == 1'b1, "R6 new entry created", dr_valid, 1);
    send(4'b1010, 32'h200, 4'hF, '0);
    chk(g_code == 2'd2 && g_rdata == 32'h1234, "R5 read data returned", g_rdata, 32'h1234);
    take_dr(); complete(g_tag, 1'b1, 32'h77);
    send(4'b1010, 32'h200, 4'h3, '0); chk(g_code == 2'd2 && g_rdata == 32'h77, "R6 second entry done", g_rdata, 32'h77);
    send(4'b1010, 32'h200, 4'h3, '0); chk(g_code == 2'd1, "R5 entry freed after done", g_code, 1);
    take_dr(); complete(g_tag, 1'b1, 32'h77);
    send(4'b1010, 32'h200, 4'h3, '0);

    // R7 / R8 full table and order
    for (int i = 1; i <= 5; i++) begin
      send(4'b0110, 32'h10 * i, 4'hF, '0);
      chk(g_code == 2'd1, "R7 read retried", g_code, 1);
    end
    for (int i = 1; i <= 4; i++) begin
      take_dr();
      chk(g_addr == 32'h10 * i, "R8 arrival order", g_addr, 32'h10 * i);
      complete(g_tag, 1'b1, rd_of(32'h10 * i));
    end
    @(negedge clk); chk(dr_valid == 1'b0, "R7 fifth request not recorded", dr_valid, 0);
    for (int i = 1; i <= 4; i++) begin
      send(4'b0110, 32'h10 * i, 4'hF, '0);
      chk(g_code == 2'd2 && g_rdata == rd_of(32'h10 * i), "R8 collected", g_rdata, rd_of(32'h10 * i));
    end
    read_trip(4'b0110, 32'h50, "R7 fifth request retried later");

    // R9 ordering
    send(4'b0111, 32'h3000, 4'hF, 32'h9); m_addr.push_back(32'h3000); m_data.push_back(32'h9);
    send(4'b0110, 32'h300, 4'hF, '0);
    take_dr(); complete(g_tag, 1'b1, rd_of(32'h300));
    send(4'b0110, 32'h300, 4'hF, '0); chk(g_code == 2'd1, "R9 older write blocks read", g_code, 1);
    pop_pw("R9 drain older write");
    send(4'b0110, 32'h300, 4'hF, '0); chk(g_code == 2'd2, "R9 read after drain", g_code, 2);
    send(4'b0110, 32'h400, 4'hF, '0);
    send(4'b0111, 32'h3004, 4'hF, 32'hA); m_addr.push_back(32'h3004); m_data.push_back(32'hA);
    take_dr(); complete(g_tag, 1'b1, rd_of(32'h400));
    send(4'b0110, 32'h400, 4'hF, '0); chk(g_code == 2'd2, "R9 younger write does not block", g_code, 2);
    pop_pw("R9 drain younger write");

    // R11 error completion
    send(4'b0010, 32'h500, 4'h1, '0);
    take_dr(); complete(g_tag, 1'b0, '0);
    send(4'b0010, 32'h500, 4'h1, '0); chk(g_code == 2'd3, "R11 abort status", g_code, 3);
    send(4'b0010, 32'h500, 4'h1, '0); chk(g_code == 2'd1, "R11 entry freed", g_code, 1);
    take_dr(); complete(g_tag, 1'b1, '0); send(4'b0010, 32'h500, 4'h1, '0);

    // R10 discard timer
    send(4'b0110, 32'h600, 4'hF, '0);
    take_dr(); complete(g_tag, 1'b1, rd_of(32'h600));
    repeat (1000) @(negedge clk);
    send(4'b0110, 32'h600, 4'hF, '0); chk(g_code == 2'd2, "R10 collected inside window", g_code, 2);
    chk(disc_cnt == 0, "R10 no early discard", disc_cnt, 0);
    send(4'b0110, 32'h700, 4'hF, '0);
    take_dr(); complete(g_tag, 1'b1, rd_of(32'h700));
    repeat (1030) @(negedge clk);
    chk(disc_cnt == 1, "R10 discard pulse", disc_cnt, 1);
    read_trip(4'b0110, 32'h700, "R10 dropped entry re-requested");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      op = $urandom_range(0, 2);
      a = {$urandom_range(0, 255), 2'b00};
      d = $urandom;
      if (op == 0) begin
        send(4'b0111, a, 4'hF, d);
        if (m_addr.size() < 4) begin
          chk(g_code == 2'd0, "R1 random posted accept", g_code, 0);
          m_addr.push_back(a); m_data.push_back(d);
        end else chk(g_code == 2'd1, "R2 random posted full", g_code, 1);
      end else if (op == 1) begin
        if (m_addr.size() > 0) pop_pw("R1 random drain");
      end else begin
        while (m_addr.size() > 0) pop_pw("R9 random drain");
        read_trip(4'b1100, a + 32'h8000, "R4 random read");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule